// File: doc/BRIEF.md
# Fully associative translation buffer with write-back dirty tracking

This block caches virtual-to-physical page translations. A lookup presents a 20-bit virtual page number, a 12-bit page offset and a read/write flag. The key is compared against all stored entries in parallel. On a hit, the block answers with the stored 14-bit real page number placed above the unchanged offset, which gives a 26-bit physical address. On a miss, it reports the miss, asks an external walker for the page table entry, installs the result, and returns to idle. The requester then retries the access.

The buffer behaves as a read-write cache of translations. The first write that hits a clean entry sets a dirty flag in the buffer only, and nothing goes to memory at that time. The page table's dirty bit is brought up to date through a write-back request when the dirty entry leaves the buffer. An entry can leave by replacement, by an invalidate of one page, or by a flush of the whole buffer. Replacement fills an empty slot first. When no slot is empty, it takes the least recently used entry, tracked with one age counter per slot.

Top module: `xlat_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `walk_req`, `wb_req` and `rsp_valid` are 0, and every entry is invalid, so the first lookup of any page misses.
- R2: A lookup accepted at a clock edge (`lk_valid` high while `req_ready` is high, with no flush or invalidate) gives `rsp_valid` high for one cycle after that edge. On a hit, `rsp_paddr` is the stored real page number in bits 25:12 and `lk_offset` in bits 11:0.
- R3: On a miss, `rsp_hit` is 0. From the next cycle on, `walk_req` stays high with `walk_vpn` equal to the missed page until `walk_done` is sampled. The installed entry then makes a retried lookup of that page hit with `walk_rpn`.
- R4: A write lookup that hits sets the entry's dirty flag and raises neither `wb_req` nor `walk_req`.
- R5: When the refill victim is valid and dirty, `wb_req` is raised with the victim's page in `wb_vpn` and held until `wb_ack`. `req_ready` stays 0 until then, and the new entry is written only after the acknowledge.
- R6: Refill takes the lowest-numbered invalid slot if one exists. Otherwise it takes the entry that has gone longest without a hit or install.
- R7: An invalidate of a page clears its entry. If the entry is dirty, a single write-back of that page comes first. An invalidate of an absent page changes nothing.
- R8: A flush clears every entry. It writes back each dirty entry, in ascending slot order, one acknowledge each.
- R9: A lookup never matches more than one entry.
- R10: Read hits never set the dirty flag, so entries that were only read are dropped without a write-back.
- R11: When several requests arrive in the same idle cycle, flush wins over invalidate, and invalidate wins over lookup. The losing lookup gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_ready | output | 1 | Idle; lookup, invalidate and flush are sampled only now |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_offset | input | 12 | Lookup page offset |
| lk_write | input | 1 | Lookup is a write |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 26 | Physical address on a hit |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page to invalidate |
| flush_all | input | 1 | Invalidate every entry |
| walk_req | output | 1 | Page table walk request |
| walk_vpn | output | 20 | Page to walk |
| walk_done | input | 1 | Walk result valid |
| walk_rpn | input | 14 | Real page number from the walk |
| wb_req | output | 1 | Dirty write-back request |
| wb_vpn | output | 20 | Page whose dirty bit must be set in the table |
| wb_ack | input | 1 | Write-back accepted |

## Verification
A lookup driven before an edge is answered in the cycle right after that edge, so the bench drives on the falling edge and reads the response on the next falling edge. If that response is a miss, `walk_req` is already high at the same sampling point. After `walk_done` is seen at an edge, the entry is installed at that same edge when the victim is clean, and `req_ready` is back one falling edge later. When the victim is dirty, `wb_req` is visible at that falling edge instead, and the bench holds off the acknowledge for several cycles to confirm that the block stalls. Flush and invalidate are drained one falling edge at a time: each write-back seen is acknowledged in that step and compared against the expected page order, until `req_ready` returns.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WALK   = 3'd1,
        ST_EVICT  = 3'd2,
        ST_INV_WB = 3'd3,
        ST_FLUSH  = 3'd4
    } tlb_state_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]       valid_vec,
    input  logic [ENTRIES*VPN_W-1:0] vpn_flat,
    input  logic [VPN_W-1:0]         key,
    output logic [ENTRIES-1:0]       match_vec,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_vec[g] && (vpn_flat[g*VPN_W +: VPN_W] == key);
    end

    assign hit = |match_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int AGE_W  = IDX_W
) (
    input  logic [ENTRIES-1:0]       valid_vec,
    input  logic [ENTRIES*AGE_W-1:0] age_flat,
    output logic [IDX_W-1:0]         vic_idx,
    output logic                     vic_used
);

    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(ENTRIES - 1);

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        old_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (age_flat[i*AGE_W +: AGE_W] == AGE_MAX) begin
                old_idx = IDX_W'(i);
            end
        end
    end

    assign vic_used = !any_free;
    assign vic_idx  = any_free ? free_idx : old_idx;

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int RPN_W   = 14,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int AGE_W  = IDX_W,
    localparam int PA_W   = RPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             req_ready,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [OFF_W-1:0] lk_offset,
    input  logic             lk_write,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PA_W-1:0]  rsp_paddr,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush_all,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_done,
    input  logic [RPN_W-1:0] walk_rpn,
    output logic             wb_req,
    output logic [VPN_W-1:0] wb_vpn,
    input  logic             wb_ack
);

    import tlb_pkg::*;

    localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [AGE_W-1:0] age;
        logic [VPN_W-1:0] vpn;
        logic [RPN_W-1:0] rpn;
    } ent_t;

    typedef ent_t [ENTRIES-1:0] tab_t;

    typedef struct packed {
        tlb_state_e       st;
        logic [IDX_W-1:0] sel;
        logic [VPN_W-1:0] miss_vpn;
        logic [RPN_W-1:0] fill_rpn;
        logic             rsp_valid;
        logic             rsp_hit;
        logic [PA_W-1:0]  rsp_paddr;
        tab_t             tab;
    } state_t;

    state_t q, d;

    logic [ENTRIES-1:0]       valid_vec;
    logic [ENTRIES*VPN_W-1:0] vpn_flat;
    logic [ENTRIES*AGE_W-1:0] age_flat;
    logic [VPN_W-1:0]         key;
    logic [ENTRIES-1:0]       match_vec;
    logic                     cam_hit;
    logic [IDX_W-1:0]         cam_idx;
    logic [IDX_W-1:0]         vic_idx;
    logic                     vic_used;
    ent_t                     cur;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            valid_vec[i]                 = q.tab[i].valid;
            vpn_flat[i*VPN_W +: VPN_W]   = q.tab[i].vpn;
            age_flat[i*AGE_W +: AGE_W]   = q.tab[i].age;
        end
    end

    assign key = inv_valid ? inv_vpn : lk_vpn;

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W)
    ) u_cam (
        .valid_vec (valid_vec),
        .vpn_flat  (vpn_flat),
        .key       (key),
        .match_vec (match_vec),
        .hit       (cam_hit),
        .hit_idx   (cam_idx)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .valid_vec (valid_vec),
        .age_flat  (age_flat),
        .vic_idx   (vic_idx),
        .vic_used  (vic_used)
    );

    // Make slot k youngest; valid peers younger than ref_age step back by one.
    function automatic tab_t touch(tab_t t, logic [IDX_W-1:0] k, logic [AGE_W-1:0] ref_age);
        tab_t r;
        r = t;
        for (int j = 0; j < ENTRIES; j++) begin
            if (t[j].valid && (IDX_W'(j) != k) && (t[j].age < ref_age)) begin
                r[j].age = t[j].age + 1'b1;
            end
        end
        r[k].age = '0;
        return r;
    endfunction

    // Remove slot k and close the gap it leaves in the age order.
    function automatic tab_t drop(tab_t t, logic [IDX_W-1:0] k);
        tab_t r;
        r = t;
        for (int j = 0; j < ENTRIES; j++) begin
            if (t[j].valid && (IDX_W'(j) != k) && (t[j].age > t[k].age)) begin
                r[j].age = t[j].age - 1'b1;
            end
        end
        r[k].valid = 1'b0;
        r[k].dirty = 1'b0;
        return r;
    endfunction

    function automatic tab_t install(tab_t t, logic [IDX_W-1:0] k,
                                     logic [VPN_W-1:0] v, logic [RPN_W-1:0] p);
        tab_t             r;
        logic [AGE_W-1:0] ref_age;
        ref_age    = t[k].valid ? t[k].age : AGE_MAX;
        r          = touch(t, k, ref_age);
        r[k].valid = 1'b1;
        r[k].dirty = 1'b0;
        r[k].vpn   = v;
        r[k].rpn   = p;
        return r;
    endfunction

    assign cur = q.tab[q.sel];

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.rsp_hit   = 1'b0;
        d.rsp_paddr = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (flush_all) begin
                    d.st  = ST_FLUSH;
                    d.sel = '0;
                end else if (inv_valid) begin
                    if (cam_hit) begin
                        if (q.tab[cam_idx].dirty) begin
                            d.sel = cam_idx;
                            d.st  = ST_INV_WB;
                        end else begin
                            d.tab = drop(q.tab, cam_idx);
                        end
                    end
                end else if (lk_valid) begin
                    d.rsp_valid = 1'b1;
                    if (cam_hit) begin
                        d.rsp_hit   = 1'b1;
                        d.rsp_paddr = {q.tab[cam_idx].rpn, lk_offset};
                        d.tab       = touch(q.tab, cam_idx, q.tab[cam_idx].age);
                        if (lk_write) begin
                            d.tab[cam_idx].dirty = 1'b1;
                        end
                    end else begin
                        d.miss_vpn = lk_vpn;
                        d.st       = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                if (walk_done) begin
                    d.fill_rpn = walk_rpn;
                    d.sel      = vic_idx;
                    if (vic_used && q.tab[vic_idx].dirty) begin
                        d.st = ST_EVICT;
                    end else begin
                        d.tab = install(q.tab, vic_idx, q.miss_vpn, walk_rpn);
                        d.st  = ST_IDLE;
                    end
                end
            end
            ST_EVICT: begin
                if (wb_ack) begin
                    d.tab = install(q.tab, q.sel, q.miss_vpn, q.fill_rpn);
                    d.st  = ST_IDLE;
                end
            end
            ST_INV_WB: begin
                if (wb_ack) begin
                    d.tab = drop(q.tab, q.sel);
                    d.st  = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                if (!(cur.valid && cur.dirty) || wb_ack) begin
                    d.tab[q.sel].valid = 1'b0;
                    d.tab[q.sel].dirty = 1'b0;
                    if (q.sel == LAST_IDX) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.sel = q.sel + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp_valid;
    assign rsp_hit   = q.rsp_hit;
    assign rsp_paddr = q.rsp_paddr;
    assign walk_req  = (q.st == ST_WALK);
    assign walk_vpn  = q.miss_vpn;
    assign wb_req    = (q.st == ST_EVICT) || (q.st == ST_INV_WB) ||
                       ((q.st == ST_FLUSH) && cur.valid && cur.dirty);
    assign wb_vpn    = cur.vpn;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R9

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid && req_ready && !flush_all && !inv_valid)); // R11

    AST_MISS_STARTS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> walk_req); // R3

    AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_done) |=> (walk_req && $stable(walk_vpn))); // R3

    AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_vpn))); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!walk_req && !wb_req)); // R5

endmodule

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_ready;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [11:0] lk_offset = '0;
    logic        lk_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [25:0] rsp_paddr;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush_all = 1'b0;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic        walk_done = 1'b0;
    logic [13:0] walk_rpn = '0;
    logic        wb_req;
    logic [19:0] wb_vpn;
    logic        wb_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [19:0] exp_wb [0:7];

    always #2.5 clk = ~clk;

    xlat_cache uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_ready (req_ready),
        .lk_valid  (lk_valid),
        .lk_vpn    (lk_vpn),
        .lk_offset (lk_offset),
        .lk_write  (lk_write),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_paddr (rsp_paddr),
        .inv_valid (inv_valid),
        .inv_vpn   (inv_vpn),
        .flush_all (flush_all),
        .walk_req  (walk_req),
        .walk_vpn  (walk_vpn),
        .walk_done (walk_done),
        .walk_rpn  (walk_rpn),
        .wb_req    (wb_req),
        .wb_vpn    (wb_vpn),
        .wb_ack    (wb_ack)
    );

    typedef struct packed {
        logic [19:0] vpn;
        logic [11:0] off;
        logic        wr;
        logic        hit;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{20'h01234, 12'h010, 1'b0, 1'b0},
        '{20'h0ABCD, 12'hFFF, 1'b1, 1'b0},
        '{20'h01234, 12'h000, 1'b0, 1'b1},
        '{20'hFFFFF, 12'h7A5, 1'b1, 1'b0},
        '{20'h0ABCD, 12'h123, 1'b0, 1'b1},
        '{20'h00000, 12'h800, 1'b0, 1'b0},
        '{20'hFFFFF, 12'h001, 1'b0, 1'b1},
        '{20'h01234, 12'h3C3, 1'b1, 1'b1}
    };

    function automatic logic [13:0] rpn_for(logic [19:0] v);
        return v[13:0] ^ 14'h15A3;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [19:0] v, input logic [11:0] off, input logic wr,
                          output logic valid, output logic hit, output logic [25:0] pa);
        @(negedge clk);
        lk_valid  = 1'b1;
        lk_vpn    = v;
        lk_offset = off;
        lk_write  = wr;
        @(negedge clk);
        valid    = rsp_valid;
        hit      = rsp_hit;
        pa       = rsp_paddr;
        lk_valid = 1'b0;
        lk_write = 1'b0;
    endtask

    task automatic expect_hit(input logic [19:0] v, input logic [11:0] off,
                              input logic wr, input string req);
        logic vl, h;
        logic [25:0] pa;
        lookup(v, off, wr, vl, h, pa);
        check(vl && h, req, "hit", {30'd0, vl, h}, 32'h3);
        check(pa == {rpn_for(v), off}, req, "paddr", {6'd0, pa}, {6'd0, rpn_for(v), off});
    endtask

    // Called right after a miss response; serves the walk and optional eviction.
    task automatic serve_walk(input logic [19:0] v, input bit want_wb,
                              input logic [19:0] wv, input string req);
        check(walk_req && walk_vpn == v, "R3", "walk request",
              {11'd0, walk_req, walk_vpn}, {11'd0, 1'b1, v});
        walk_done = 1'b1;
        walk_rpn  = rpn_for(v);
        @(negedge clk);
        walk_done = 1'b0;
        if (want_wb) begin
            check(wb_req && wb_vpn == wv && !req_ready, req, "evict write-back",
                  {10'd0, req_ready, wb_req, wb_vpn}, {10'd0, 1'b0, 1'b1, wv});
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(wb_req && !req_ready && wb_vpn == wv, req, "stall until ack",
                      {10'd0, req_ready, wb_req, wb_vpn}, {10'd0, 1'b0, 1'b1, wv});
            end
            wb_ack = 1'b1;
            @(negedge clk);
            wb_ack = 1'b0;
        end else begin
            check(!wb_req, req, "no write-back on clean victim", {31'd0, wb_req}, 32'd0);
        end
        check(req_ready, "R3", "ready after refill", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic expect_miss(input logic [19:0] v, input bit want_wb,
                               input logic [19:0] wv, input string req);
        logic vl, h;
        logic [25:0] pa;
        lookup(v, 12'h0, 1'b0, vl, h, pa);
        check(vl && !h, req, "miss", {30'd0, vl, h}, 32'h2);
        serve_walk(v, want_wb, wv, req);
    endtask

    // Steps through a flush or invalidate, acknowledging each write-back.
    task automatic drain(input int n_exp, input string req);
        int n = 0;
        bit done = 0;
        for (int c = 0; c < 200 && !done; c++) begin
            @(negedge clk);
            flush_all = 1'b0;
            inv_valid = 1'b0;
            wb_ack    = 1'b0;
            if (req_ready) begin
                done = 1;
            end else if (wb_req) begin
                if (n < n_exp) begin
                    check(wb_vpn == exp_wb[n], req, "write-back page",
                          {12'd0, wb_vpn}, {12'd0, exp_wb[n]});
                end
                n++;
                wb_ack = 1'b1;
            end
        end
        check(done, req, "returned to idle", {31'd0, done}, 32'd1);
        check(n == n_exp, req, "write-back count", n, n_exp);
    endtask

    task automatic do_flush(input int n_exp, input string req);
        @(negedge clk);
        flush_all = 1'b1;
        drain(n_exp, req);
    endtask

    task automatic do_inv(input logic [19:0] v, input int n_exp, input string req);
        @(negedge clk);
        inv_valid = 1'b1;
        inv_vpn   = v;
        drain(n_exp, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic vl, h;
        logic [25:0] pa;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready && !walk_req && !wb_req && !rsp_valid, "R1", "reset outputs",
              {28'd0, req_ready, walk_req, wb_req, rsp_valid}, 32'h8);

        // Vector table: R2/R3/R4, misses refilled and retried
        foreach (TBL[i]) begin
            lookup(TBL[i].vpn, TBL[i].off, TBL[i].wr, vl, h, pa);
            check(vl && (h == TBL[i].hit), i == 0 ? "R1" : "R2", "table hit flag",
                  {30'd0, vl, h}, {30'd0, 1'b1, TBL[i].hit});
            if (TBL[i].hit) begin
                check(pa == {rpn_for(TBL[i].vpn), TBL[i].off}, "R2", "table paddr",
                      {6'd0, pa}, {6'd0, rpn_for(TBL[i].vpn), TBL[i].off});
            end else begin
                serve_walk(TBL[i].vpn, 1'b0, 20'h0, "R6");
                expect_hit(TBL[i].vpn, TBL[i].off, TBL[i].wr, "R3");
            end
            check(!wb_req, "R4", "no write-back after lookup", {31'd0, wb_req}, 32'd0);
        end

        // R8: dirty pages in slot order 0,1,2; slot 3 clean
        exp_wb[0] = 20'h01234;
        exp_wb[1] = 20'h0ABCD;
        exp_wb[2] = 20'hFFFFF;
        do_flush(3, "R8");
        expect_miss(20'h00000, 1'b0, 20'h0, "R8");
        expect_miss(20'h01234, 1'b0, 20'h0, "R8");
        do_flush(0, "R8");

        // R7: invalidate
        lookup(20'h55555, 12'h0, 1'b1, vl, h, pa);
        check(vl && !h, "R7", "setup miss", {30'd0, vl, h}, 32'h2);
        serve_walk(20'h55555, 1'b0, 20'h0, "R7");
        expect_hit(20'h55555, 12'h0AA, 1'b1, "R4");
        expect_miss(20'h0AAAA, 1'b0, 20'h0, "R7");
        do_inv(20'h0AAAA, 0, "R7");
        expect_miss(20'h0AAAA, 1'b0, 20'h0, "R7");
        do_inv(20'h77777, 0, "R7");
        expect_hit(20'h0AAAA, 12'h5F0, 1'b0, "R7");
        exp_wb[0] = 20'h55555;
        do_inv(20'h55555, 1, "R7");
        expect_miss(20'h55555, 1'b0, 20'h0, "R7");

        // R11: invalidate beats lookup in the same cycle
        @(negedge clk);
        inv_valid = 1'b1;
        inv_vpn   = 20'h0AAAA;
        lk_valid  = 1'b1;
        lk_vpn    = 20'h0AAAA;
        @(negedge clk);
        check(!rsp_valid && req_ready, "R11", "lookup dropped under invalidate",
              {30'd0, rsp_valid, req_ready}, 32'h1);
        inv_valid = 1'b0;
        lk_valid  = 1'b0;
        expect_miss(20'h0AAAA, 1'b0, 20'h0, "R11");

        // R11: flush beats lookup
        @(negedge clk);
        flush_all = 1'b1;
        lk_valid  = 1'b1;
        lk_vpn    = 20'h0AAAA;
        @(negedge clk);
        check(!rsp_valid && !req_ready, "R11", "lookup dropped under flush",
              {30'd0, rsp_valid, req_ready}, 32'h0);
        flush_all = 1'b0;
        lk_valid  = 1'b0;
        drain(0, "R11");
        expect_miss(20'h0AAAA, 1'b0, 20'h0, "R11");
        do_flush(0, "R11");

        // Fill all slots; first page written so it is dirty and oldest
        for (int i = 0; i < 32; i++) begin
            expect_miss(20'h30000 + 20'(i), 1'b0, 20'h0, "R6");
            if (i == 0) begin
                expect_hit(20'h30000, 12'h044, 1'b1, "R4");
                check(!wb_req && !walk_req, "R4", "write hit quiet",
                      {30'd0, wb_req, walk_req}, 32'd0);
                @(negedge clk);
                check(!wb_req && !walk_req, "R4", "write hit quiet later",
                      {30'd0, wb_req, walk_req}, 32'd0);
            end
        end
        expect_hit(20'h30001, 12'h321, 1'b0, "R10");
        expect_miss(20'h4AAAA, 1'b1, 20'h30000, "R5");
        expect_hit(20'h4AAAA, 12'h9E1, 1'b0, "R5");
        expect_miss(20'h4BBBB, 1'b0, 20'h0, "R6");
        expect_hit(20'h30001, 12'h001, 1'b0, "R6");
        expect_miss(20'h30002, 1'b0, 20'h0, "R6");
        expect_miss(20'h30000, 1'b0, 20'h0, "R5");
        // R10: only read hits remain, so flush writes nothing back
        do_flush(0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule